// File: doc/BRIEF.md
# DDR Read Burst Truncation Sequencer

This block turns read requests into DDR SDRAM command-bus traffic, one command per clock. Each read request names a bank, a column, a burst length of 4 or 8, a count of wanted data pairs, an end code and an auto-precharge bit. The block sends READ. It then either lets the burst run out, or cuts it short with Burst Terminate or with a bank PRECHARGE. The cut-off command is placed exactly as many cycles after READ as the number of pairs wanted, because the 2n prefetch delivers data two words at a time. This placement does not change with read latency, so latencies of 2 and 2.5 both use the same command schedule.

A separate write request stream shares the command bus. While a read burst is still in flight, writes are held. A write waits at each bank until the row-precharge time has passed, and so does a read to that bank. A held request is never dropped. A single-cycle flag marks the first cycle it is held by an ordering rule. Malformed read requests are taken off the stream at once and flagged.

Both request streams use valid/ready. A handshake happens on a rising edge where valid and ready are both high. While valid is high and ready is low, the requester must keep the fields stable. The ready outputs depend on the current request fields and on internal state, not on the clock edge. The row-precharge time is a static input given in clock cycles.

Top module: `ddr_trunc_seq`

## Requirements
- R1: After reset the command bus shows NOP ({cs_n,ras_n,cas_n,we_n} = 0111), with bank and address zero, and busy, req_err and rule_viol are low.
- R2: An accepted valid read puts READ (0101) on the bus in the next cycle. The READ carries the request bank on cmd_ba, the column in cmd_addr[COL_W-1:0] and the auto-precharge bit in cmd_addr[10].
- R3: With end code 1 (terminate), Burst Terminate (0110) appears exactly N cycles after READ, where N is rd_pairs. Only NOP is driven between the two commands.
- R4: With end code 2 (precharge), PRECHARGE (0010) to the read's bank, with cmd_addr[10]=0, appears exactly N cycles after READ.
- R5: With end code 0 (complete), no end command is driven. For every end code, busy is high for N cycles starting with the READ cycle, where N is BL/2 for a complete read (BL/2 is 2 when rd_bl8=0 and 4 when rd_bl8=1).
- R6: A read is rejected if it has end code 3, has auto-precharge with a non-zero end code, or has end code 1 or 2 with rd_pairs of 0 or above BL/2. A rejected read is accepted with rd_ready high and produces no command. req_err is then high for exactly the following cycle.
- R7: wr_ready is low while busy is high. WRITE (0100, cmd_addr[10]=0) appears the cycle after the write handshake. A write waiting behind a read that ends at READ+N is issued at READ+N+1, as long as its bank is free.
- R8: After a PRECHARGE in cycle p with precharge time T≥1, a read or write to that bank waiting for it is issued exactly in cycle p+T, and not earlier.
- R9: A complete read with auto-precharge blocks its bank for the same cycles as a precharge-ended read with N = BL/2.
- R10: A request held because a read is in flight (writes) or because its bank is in precharge time raises rule_viol in the first held cycle only. It is issued later and is not lost.
- R11: Precharge time on one bank does not delay a request to another bank.
- R12: When a read and a write can both go in the same cycle, the read goes first. Losing that arbitration does not raise rule_viol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trp_cycles | input | TRP_W | Row precharge time in clock cycles |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted this cycle if valid |
| rd_bank | input | BANK_W | Read bank |
| rd_col | input | COL_W | Read column |
| rd_bl8 | input | 1 | 1: burst length 8, 0: burst length 4 |
| rd_pairs | input | PAIR_W | Wanted data pairs before truncation |
| rd_end | input | 2 | 0 complete, 1 terminate, 2 precharge, 3 reserved |
| rd_ap | input | 1 | Auto-precharge on this read |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted this cycle if valid |
| wr_bank | input | BANK_W | Write bank |
| wr_col | input | COL_W | Write column |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BANK_W | Command bank address |
| cmd_addr | output | ADDR_W | Command address, bit 10 is the precharge/auto-precharge bit |
| busy | output | 1 | A read burst is in flight |
| req_err | output | 1 | One-cycle flag for a rejected read |
| rule_viol | output | 1 | One-cycle flag for a request first held by an ordering rule |

## Verification
If the burst counter is loaded wrongly, the Burst Terminate or PRECHARGE moves off its READ+N slot. The same fault shifts where busy falls, and both show on the bus within at most four cycles of READ. If a bank timer is loaded with the wrong value or drains at the wrong rate, a waiting read or write appears one or more cycles away from p+T. A wrong bank index shows up as a request on an idle bank that waits for no reason. A stuck held flag either hides rule_viol or repeats it, which shows in the very next held cycle.

// File: rtl/ddr_trunc_pkg.sv
package ddr_trunc_pkg;

  typedef enum logic [2:0] {
    C_NOP,
    C_READ,
    C_WRITE,
    C_BST,
    C_PRE
  } cmd_e;

  localparam logic [1:0] END_FULL = 2'd0;
  localparam logic [1:0] END_BST  = 2'd1;
  localparam logic [1:0] END_PRE  = 2'd2;

  // Bus pins in the order {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] cmd_pins(cmd_e c);
    case (c)
      C_READ:  return 4'b0101;
      C_WRITE: return 4'b0100;
      C_BST:   return 4'b0110;
      C_PRE:   return 4'b0010;
      default: return 4'b0111;
    endcase
  endfunction

endpackage

// File: rtl/ddr_bank_tmr.sv
module ddr_bank_tmr #(
  parameter int TRP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TRP_W-1:0] load_val,
  output logic             zero
);

  logic [TRP_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R8
  tmr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == TRP_W'($past(cnt_q) - 1'b1)));

endmodule

// File: rtl/ddr_rd_track.sv
module ddr_rd_track #(
  parameter int PAIR_W = 3,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAIR_W-1:0] len,
  input  logic [1:0]        endk,
  input  logic              ap,
  input  logic [BANK_W-1:0] bank,
  output logic              act,
  output logic              fire,
  output logic [1:0]        fire_end,
  output logic              fire_ap,
  output logic [BANK_W-1:0] fire_bank
);

  logic [PAIR_W-1:0] cnt_q;
  logic [1:0]        end_q;
  logic              ap_q;
  logic [BANK_W-1:0] bank_q;
  logic              act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      end_q  <= '0;
      ap_q   <= 1'b0;
      bank_q <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      cnt_q  <= len;
      end_q  <= endk;
      ap_q   <= ap;
      bank_q <= bank;
    end else if (fire) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (act_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  // The last pair of the wanted window is in flight: the end action goes out next cycle
  assign fire      = act_q && (cnt_q == PAIR_W'(1));
  assign act       = act_q;
  assign fire_end  = end_q;
  assign fire_ap   = ap_q;
  assign fire_bank = bank_q;

  // R5
  act_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q != '0));

  // R6
  start_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (len != '0 && !act_q));

endmodule

// File: rtl/ddr_cmd_drv.sv
module ddr_cmd_drv
  import ddr_trunc_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              nxt,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic              ap,
  output logic [3:0]        pins,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int AP_BIT = 10;

  logic [ADDR_W-1:0] addr_n;
  logic [BANK_W-1:0] ba_n;

  always_comb begin
    addr_n = '0;
    ba_n   = '0;
    case (nxt)
      C_READ, C_WRITE: begin
        addr_n[COL_W-1:0] = col;
        addr_n[AP_BIT]    = ap;
        ba_n              = bank;
      end
      C_PRE: begin
        addr_n[AP_BIT]    = 1'b0;
        ba_n              = bank;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins <= cmd_pins(C_NOP);
      ba   <= '0;
      addr <= '0;
    end else begin
      pins <= cmd_pins(nxt);
      ba   <= ba_n;
      addr <= addr_n;
    end
  end

endmodule

// File: rtl/ddr_trunc_seq.sv
module ddr_trunc_seq
  import ddr_trunc_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13,
  parameter int PAIR_W = 3,
  parameter int TRP_W  = 4,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRP_W-1:0]  trp_cycles,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [COL_W-1:0]  rd_col,
  input  logic              rd_bl8,
  input  logic [PAIR_W-1:0] rd_pairs,
  input  logic [1:0]        rd_end,
  input  logic              rd_ap,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [COL_W-1:0]  wr_col,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BANK_W-1:0] cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              busy,
  output logic              req_err,
  output logic              rule_viol
);

  localparam logic [PAIR_W-1:0] HALF_BL4 = PAIR_W'(2);
  localparam logic [PAIR_W-1:0] HALF_BL8 = PAIR_W'(4);

  // ---------------- request checks ----------------
  logic [PAIR_W-1:0] half;
  logic [PAIR_W-1:0] rd_len;
  logic              rd_bad;

  always_comb begin
    half   = rd_bl8 ? HALF_BL8 : HALF_BL4;
    rd_len = (rd_end == END_FULL) ? half : rd_pairs;
    rd_bad = (rd_end == 2'd3)
           || (rd_ap && rd_end != END_FULL)
           || (rd_end != END_FULL && (rd_pairs == '0 || rd_pairs > half));
  end

  // ---------------- burst tracker ----------------
  logic              act, fire, fire_ap;
  logic [1:0]        fire_end;
  logic [BANK_W-1:0] fire_bank;
  logic              rd_go, wr_go;

  ddr_rd_track #(.PAIR_W(PAIR_W), .BANK_W(BANK_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (rd_go),
    .len       (rd_len),
    .endk      (rd_end),
    .ap        (rd_ap),
    .bank      (rd_bank),
    .act       (act),
    .fire      (fire),
    .fire_end  (fire_end),
    .fire_ap   (fire_ap),
    .fire_bank (fire_bank)
  );

  // ---------------- per-bank precharge timers ----------------
  logic [BANKS-1:0] tmr_zero;
  logic [BANKS-1:0] tmr_load;
  logic [TRP_W-1:0] trp_ld;
  logic             pre_evt;

  assign trp_ld  = (trp_cycles == '0) ? '0 : trp_cycles - 1'b1;
  // Explicit precharge and auto-precharge both close the bank at the fire edge
  assign pre_evt = fire && (fire_end == END_PRE || (fire_end == END_FULL && fire_ap));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign tmr_load[b] = pre_evt && (fire_bank == BANK_W'(b));
    ddr_bank_tmr #(.TRP_W(TRP_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load[b]),
      .load_val (trp_ld),
      .zero     (tmr_zero[b])
    );
  end

  // ---------------- arbitration ----------------
  logic rd_free, wr_free;
  logic rd_rule, wr_rule;
  logic rd_held_q, wr_held_q;

  always_comb begin
    rd_free  = tmr_zero[rd_bank];
    wr_free  = tmr_zero[wr_bank];
    rd_ready = rd_bad || (!act && rd_free);
    rd_go    = rd_valid && !rd_bad && !act && rd_free;
    wr_ready = !act && wr_free && !rd_go;
    wr_go    = wr_valid && wr_ready;
    rd_rule  = rd_valid && !rd_bad && !rd_free;
    wr_rule  = wr_valid && (act || !wr_free);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_held_q <= 1'b0;
      wr_held_q <= 1'b0;
      req_err   <= 1'b0;
    end else begin
      rd_held_q <= rd_rule;
      wr_held_q <= wr_rule;
      req_err   <= rd_valid && rd_bad;
    end
  end

  assign rule_viol = (rd_rule && !rd_held_q) || (wr_rule && !wr_held_q);
  assign busy      = act;

  // ---------------- next command ----------------
  cmd_e              nxt;
  logic [BANK_W-1:0] nxt_bank;
  logic [COL_W-1:0]  nxt_col;
  logic              nxt_ap;

  always_comb begin
    nxt      = C_NOP;
    nxt_bank = '0;
    nxt_col  = '0;
    nxt_ap   = 1'b0;
    if (rd_go) begin
      nxt      = C_READ;
      nxt_bank = rd_bank;
      nxt_col  = rd_col;
      nxt_ap   = rd_ap;
    end else if (wr_go) begin
      nxt      = C_WRITE;
      nxt_bank = wr_bank;
      nxt_col  = wr_col;
    end else if (fire && fire_end == END_BST) begin
      nxt      = C_BST;
    end else if (fire && fire_end == END_PRE) begin
      nxt      = C_PRE;
      nxt_bank = fire_bank;
    end
  end

  logic [3:0] pins;

  ddr_cmd_drv #(.BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_drv (
    .clk   (clk),
    .rst_n (rst_n),
    .nxt   (nxt),
    .bank  (nxt_bank),
    .col   (nxt_col),
    .ap    (nxt_ap),
    .pins  (pins),
    .ba    (cmd_ba),
    .addr  (cmd_addr)
  );

  assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = pins;

  // R2
  rd_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !rd_bad) |=> (pins == 4'b0101 && busy));

  // R6
  rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_bad) |=> (req_err && pins != 4'b0101));

  // R7
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0100) |-> !$past(busy));

  // R3
  bst_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0110) |-> ($past(busy) && !busy));

endmodule

// File: tb/test_ddr_trunc_seq.sv
module test_ddr_trunc_seq;

  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_RD  = 4'b0101;
  localparam logic [3:0] P_WR  = 4'b0100;
  localparam logic [3:0] P_BST = 4'b0110;
  localparam logic [3:0] P_PRE = 4'b0010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  trp_cycles = 4'd1;
  logic        rd_valid = 1'b0, rd_ready;
  logic [1:0]  rd_bank = '0;
  logic [9:0]  rd_col = '0;
  logic        rd_bl8 = 1'b0;
  logic [2:0]  rd_pairs = '0;
  logic [1:0]  rd_end = '0;
  logic        rd_ap = 1'b0;
  logic        wr_valid = 1'b0, wr_ready;
  logic [1:0]  wr_bank = '0;
  logic [9:0]  wr_col = '0;
  logic        cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [1:0]  cmd_ba;
  logic [12:0] cmd_addr;
  logic        busy, req_err, rule_viol;

  int n_chk = 0;
  int n_bad = 0;
  int case_no = 0;

  always #10 clk = ~clk;

  ddr_trunc_seq i_ddr_trunc_seq (
    .clk(clk), .rst_n(rst_n), .trp_cycles(trp_cycles),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_bank(rd_bank), .rd_col(rd_col),
    .rd_bl8(rd_bl8), .rd_pairs(rd_pairs), .rd_end(rd_end), .rd_ap(rd_ap),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_bank(wr_bank), .wr_col(wr_col),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .busy(busy), .req_err(req_err), .rule_viol(rule_viol)
  );

  function automatic logic [3:0] pins();
    return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s case %0d %s: actual=%0h expected=%0h", rq, case_no, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // One read, optionally with a competing write (ww: 0 none, 1 same bank, 2 other bank)
  task automatic run_case(input int bl8, input int endk, input int pairs, input int ap,
                          input int trp, input int ww);
    int bank  = case_no % 4;
    int wbank = (ww == 1) ? bank : (bank + 1) % 4;
    int col   = (case_no * 37) % 1024;
    int half  = bl8 ? 4 : 2;
    int n     = (endk == 0) ? half : pairs;
    bit has_pre = (endk == 2) || (endk == 0 && ap != 0);
    int hw    = n + ((has_pre && ww == 1) ? ((trp > 0) ? trp - 1 : 0) : 0);
    logic [3:0]  ep;
    string       rq;
    @(negedge clk);
    trp_cycles = 4'(trp);
    rd_valid = 1'b1; rd_bank = 2'(bank); rd_col = 10'(col); rd_bl8 = 1'(bl8);
    rd_pairs = 3'(pairs); rd_end = 2'(endk); rd_ap = 1'(ap);
    wr_valid = (ww != 0); wr_bank = 2'(wbank); wr_col = 10'(col ^ 1);
    #1;
    chk(rd_ready == 1'b1, "R2", "rd_ready", int'(rd_ready), 1);
    if (ww != 0) chk(wr_ready == 1'b0, "R12", "wr_ready lost arb", int'(wr_ready), 0);
    chk(rule_viol == 1'b0, "R12", "viol on arb", int'(rule_viol), 0);
    @(negedge clk);
    rd_valid = 1'b0;
    for (int k = 0; k <= n + trp + 3; k++) begin
      if (k > 0) @(negedge clk);
      if (ww != 0 && k == hw + 1) wr_valid = 1'b0;
      #1;
      ep = P_NOP;
      rq = (endk == 1) ? "R3" : (endk == 2) ? "R4" : "R5";
      if (k == 0) ep = P_RD;
      else if (k == n && endk == 1) ep = P_BST;
      else if (k == n && endk == 2) ep = P_PRE;
      else if (ww != 0 && k == hw + 1) begin
        ep = P_WR;
        rq = (has_pre && ww == 1) ? ((endk == 0) ? "R9" : "R8") : "R7";
      end
      chk(pins() == ep, rq, $sformatf("cmd at READ+%0d", k), int'(pins()), int'(ep));
      if (k == 0) begin
        chk(cmd_ba == 2'(bank) && cmd_addr == {2'b00, 1'(ap), 10'(col)}, "R2",
            "READ bank/addr", int'({cmd_ba, cmd_addr}), int'({2'(bank), 2'b00, 1'(ap), 10'(col)}));
      end else if (ep == P_PRE) begin
        chk(cmd_ba == 2'(bank) && cmd_addr[10] == 1'b0, "R4", "PRE bank",
            int'({cmd_ba, cmd_addr[10]}), int'({2'(bank), 1'b0}));
      end else if (ep == P_WR) begin
        chk(cmd_ba == 2'(wbank) && cmd_addr == {3'b000, 10'(col ^ 1)}, "R7", "WRITE bank/addr",
            int'({cmd_ba, cmd_addr}), int'({2'(wbank), 3'b000, 10'(col ^ 1)}));
      end
      chk(busy == (k < n), "R5", $sformatf("busy at READ+%0d", k), int'(busy), int'(k < n));
      chk(rule_viol == (ww != 0 && k == 0), "R10", $sformatf("viol at READ+%0d", k),
          int'(rule_viol), int'(ww != 0 && k == 0));
      if (ww != 0 && k < hw)  chk(wr_ready == 1'b0, "R7", "wr_ready held", int'(wr_ready), 0);
      if (ww != 0 && k == hw) chk(wr_ready == 1'b1, "R7", "wr_ready released", int'(wr_ready), 1);
    end
    case_no++;
  endtask

  task automatic reject_case(input int bl8, input int endk, input int pairs, input int ap);
    @(negedge clk);
    rd_valid = 1'b1; rd_bl8 = 1'(bl8); rd_end = 2'(endk); rd_pairs = 3'(pairs); rd_ap = 1'(ap);
    rd_bank = 2'(case_no % 4);
    #1;
    chk(rd_ready == 1'b1, "R6", "reject ready", int'(rd_ready), 1);
    @(negedge clk);
    rd_valid = 1'b0;
    #1;
    chk(req_err == 1'b1, "R6", "req_err pulse", int'(req_err), 1);
    chk(pins() == P_NOP && busy == 1'b0, "R6", "no command", int'({busy, pins()}), int'(P_NOP));
    @(negedge clk);
    #1;
    chk(req_err == 1'b0, "R6", "req_err one cycle", int'(req_err), 0);
    chk(pins() == P_NOP, "R6", "still NOP", int'(pins()), int'(P_NOP));
    case_no++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(pins() == P_NOP && cmd_ba == '0 && cmd_addr == '0, "R1", "bus in reset",
        int'({cmd_ba, cmd_addr, pins()}), int'(P_NOP));
    chk(!busy && !req_err && !rule_viol, "R1", "flags in reset",
        int'({busy, req_err, rule_viol}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(pins() == P_NOP && !busy, "R1", "idle after reset", int'({busy, pins()}), int'(P_NOP));

    // Sweep: burst length x end action x pair count x auto-precharge x tRP x write companion
    for (int bl8 = 0; bl8 < 2; bl8++)
      for (int endk = 0; endk < 3; endk++)
        for (int pairs = 1; pairs <= (bl8 ? 4 : 2); pairs++)
          for (int ap = 0; ap < 2; ap++)
            for (int ti = 0; ti < 3; ti++)
              for (int ww = 0; ww < 3; ww++) begin
                if (endk == 0 && pairs != 1) continue;
                if (endk != 0 && ap != 0) continue;
                run_case(bl8, endk, pairs, ap, (ti == 0) ? 1 : (ti == 1) ? 2 : 5, ww);
              end

    // R6 rejections
    reject_case(0, 1, 0, 0);
    reject_case(0, 2, 3, 0);
    reject_case(1, 1, 5, 0);
    reject_case(1, 3, 2, 0);
    reject_case(1, 1, 2, 1);
    reject_case(0, 2, 1, 1);

    // R8 / R10: read to a bank waiting out its precharge time
    @(negedge clk);
    trp_cycles = 4'd4;
    rd_valid = 1'b1; rd_bank = 2'd2; rd_end = 2'd2; rd_pairs = 3'd2; rd_bl8 = 1'b0; rd_ap = 1'b0;
    @(negedge clk);                                   // READ cycle t
    rd_end = 2'd0; rd_col = 10'd5;
    #1;
    chk(rd_ready == 1'b0 && rule_viol == 1'b0, "R10", "busy hold is not a rule hold",
        int'({rd_ready, rule_viol}), 0);
    @(negedge clk); #1;                               // t+1
    chk(pins() == P_NOP && rule_viol == 1'b0, "R10", "t+1", int'({rule_viol, pins()}), int'(P_NOP));
    @(negedge clk); #1;                               // p = t+2
    chk(pins() == P_PRE && cmd_ba == 2'd2, "R4", "PRE bank 2", int'({cmd_ba, pins()}), int'({2'd2, P_PRE}));
    chk(rule_viol == 1'b1 && rd_ready == 1'b0, "R10", "first held cycle", int'({rule_viol, rd_ready}), 2);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk); #1;
      chk(rule_viol == 1'b0, "R10", "single pulse", int'(rule_viol), 0);
      chk(pins() == P_NOP, "R8", "no early command", int'(pins()), int'(P_NOP));
      chk(rd_ready == (k == 3), "R8", "ready at p+T-1", int'(rd_ready), int'(k == 3));
    end
    @(negedge clk);                                   // p+4
    rd_valid = 1'b0;
    #1;
    chk(pins() == P_RD && cmd_ba == 2'd2, "R8", "READ at p+T", int'({cmd_ba, pins()}), int'({2'd2, P_RD}));
    repeat (4) @(negedge clk);

    // R11 / R10: other bank free during precharge; write held by bank timer
    trp_cycles = 4'd6;
    rd_valid = 1'b1; rd_bank = 2'd0; rd_end = 2'd2; rd_pairs = 3'd1; rd_bl8 = 1'b0;
    @(negedge clk);                                   // t
    rd_valid = 1'b0;
    @(negedge clk); #1;                               // p = t+1
    chk(pins() == P_PRE && cmd_ba == 2'd0, "R4", "PRE bank 0", int'({cmd_ba, pins()}), int'(P_PRE));
    rd_valid = 1'b1; rd_bank = 2'd1; rd_end = 2'd1; rd_pairs = 3'd1;
    #1;
    chk(rd_ready == 1'b1 && rule_viol == 1'b0, "R11", "other bank ready", int'({rd_ready, rule_viol}), 2);
    @(negedge clk);                                   // p+1
    rd_valid = 1'b0;
    #1;
    chk(pins() == P_RD && cmd_ba == 2'd1, "R11", "READ bank 1", int'({cmd_ba, pins()}), int'({2'd1, P_RD}));
    @(negedge clk);                                   // p+2
    wr_valid = 1'b1; wr_bank = 2'd0; wr_col = 10'd9;
    #1;
    chk(pins() == P_BST, "R3", "BST after one pair", int'(pins()), int'(P_BST));
    chk(rule_viol == 1'b1 && wr_ready == 1'b0, "R10", "write held by tRP", int'({rule_viol, wr_ready}), 2);
    for (int k = 3; k <= 5; k++) begin
      @(negedge clk); #1;
      chk(wr_ready == (k == 5) && rule_viol == 1'b0, "R8", $sformatf("write wait p+%0d", k),
          int'({wr_ready, rule_viol}), int'({(k == 5), 1'b0}));
    end
    @(negedge clk);                                   // p+6
    wr_valid = 1'b0;
    #1;
    chk(pins() == P_WR && cmd_ba == 2'd0, "R8", "WRITE at p+T", int'({cmd_ba, pins()}), int'({2'd0, P_WR}));
    repeat (3) @(negedge clk);

    finish_run();
  end

endmodule